// File: doc/BRIEF.md
# Switch Register Indirect Access Bridge

This block lets a host reach the 32-bit register space of an Ethernet switch that is wired only to a 16-bit management bus. The host gives one request: a register address, a read or write flag and a 32-bit write value. The bridge turns it into three management-bus transactions. The first selects the page. The next two move the two 16-bit halves to PHY and register numbers taken from the address bits. For a read, the bridge rebuilds the 32-bit word and returns it. The management bus is reached through a request/acknowledge port. An external MDIO master serves that port and may take any number of cycles to acknowledge.

A second mode reaches a PHY that is built into the switch. It does this through a mailbox register at switch address 0x98. The bridge reads the mailbox once, which is a dummy read. It then writes a command word that carries the PHY number, the PHY register and the data. It then keeps reading the mailbox until the busy flag drops. The low 16 bits of the last mailbox read are the result.

The bridge takes one request at a time. It reports completion with a one-cycle done pulse. It also holds a sticky error flag if the management bus reported a failure on any transaction of the current request.

Top module: `swreg_bridge`

## Requirements
- R1: Every 32-bit access starts with a management write of `address >> 9` (zero-extended to 16 bits) to the page-select pair PHY 0x18, register 0.
- R2: The data phase uses PHY number `0x10 | address[8:6]`. It uses register `{address[5:2],0}` for the low half and `{address[5:2],1}` for the high half.
- R3: A direct read fetches the low half first, then the high half. It returns `rdata = {high, low}`.
- R4: A direct write sends the high half (`wdata[31:16]`) first and the low half second. The one exception is address 0x98, which takes the low half first. A direct write leaves `rdata` unchanged.
- R5: `ready` is 1 only when the bridge is idle. A `req_valid` pulse while `ready` is 0 is ignored and starts no management traffic.
- R6: `done` is high for exactly one cycle. That cycle is the one after the acknowledge of the last management transaction of the request.
- R7: `err` goes to 1 if any transaction of the current request is acknowledged with `mdio_fail` = 1. The sequence still runs to completion. `err` stays set until the next request is accepted, which clears it.
- R8: In embedded-PHY mode (`req_phy_mode` = 1), the bridge first does a dummy 32-bit read of switch address 0x98. It then writes 0x98 with this command word: bit 31 = 1 (busy), bit 30 = 1, bit 27 = 1 for a read and 0 for a write, bits 25:21 = `req_dev_phy`, bits 20:16 = `req_dev_reg`, and bits 15:0 = `req_wdata[15:0]` for a write or 0 for a read.
- R9: In embedded-PHY mode, after the command the bridge reads 0x98 again and again until bit 31 of the read word is 0. It then returns `rdata = {16'h0, bits 15:0 of that last word}`.
- R10: While `mdio_req` is 1 and no acknowledge has arrived, `mdio_req` stays 1. `mdio_write`, `mdio_phy`, `mdio_reg` and `mdio_wdata` hold their values.
- R11: After reset, `ready` = 1, `done` = 0, `err` = 0 and `mdio_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy_mode | input | 1 | 1 = embedded-PHY mailbox access, 0 = direct switch register access |
| req_addr | input | ADDR_W | Switch register address (direct mode) |
| req_wdata | input | 32 | Write data (embedded-PHY mode uses bits 15:0) |
| req_dev_phy | input | 5 | Embedded PHY number |
| req_dev_reg | input | 5 | Embedded PHY register number |
| ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result |
| err | output | 1 | Sticky failure flag of the current request |
| mdio_req | output | 1 | Management transaction request |
| mdio_write | output | 1 | 1 = management write |
| mdio_phy | output | 5 | Management PHY number |
| mdio_reg | output | 5 | Management register number |
| mdio_wdata | output | 16 | Management write data |
| mdio_ack | input | 1 | Transaction accepted and finished |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |
| mdio_fail | input | 1 | Transaction failed, valid with `mdio_ack` |

## Verification
The hardest case to reach from the ports is the mailbox poll loop. It needs the busy flag to stay set over several complete 32-bit reads and then drop, so the bridge has to walk its whole sequence many times. The bench's bus responder keeps a model of the switch. It tracks the selected page and arms a busy countdown when it sees the command's high half written with bit 15 set. It then reports busy on the next three high-half mailbox reads. From this model the bench checks the exact number and order of transactions, the split command word and the returned data. Failure injection at a chosen transaction index, plus a request pulsed while the bridge is busy, cover the error and ignore paths.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  // Word engine: page select, then two half-word phases
  typedef enum logic [1:0] {E_IDLE, E_PAGE, E_FIRST, E_SECOND} eng_state_t;

  // Request sequencer
  typedef enum logic [2:0] {T_IDLE, T_DIRECT, T_DUMMY, T_CMD, T_POLL} seq_state_t;

  // Mailbox register for embedded-PHY access and its field positions
  localparam int unsigned MBOX_ADDR  = 32'h98;
  localparam int unsigned MB_BUSY    = 31;
  localparam int unsigned MB_GO      = 30;
  localparam int unsigned MB_RD      = 27;
  localparam int unsigned MB_PHY_LSB = 21;
  localparam int unsigned MB_REG_LSB = 16;

  // Register whose halves must be written low first
  localparam int unsigned LO_FIRST_ADDR = 32'h98;
endpackage

// File: rtl/swreg_addr_map.sv
module swreg_addr_map #(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned SWAP_ADDR    = 32'h98
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       page,
  output logic [4:0]        data_phy,
  output logic [4:0]        data_reg,
  output logic              lo_first
);
  localparam int unsigned PAGE_W = ADDR_W - 9;

  generate
    if (PAGE_W >= 16) begin : g_page_trunc
      assign page = addr[24:9];
    end else begin : g_page_pad
      assign page = {{(16-PAGE_W){1'b0}}, addr[ADDR_W-1:9]};
    end
  endgenerate

  assign data_phy = {2'b10, addr[8:6]};
  assign data_reg = {addr[5:2], 1'b0};
  assign lo_first = (addr == ADDR_W'(SWAP_ADDR));
endmodule

// File: rtl/swreg_word_engine.sv
module swreg_word_engine
  import swreg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter logic [4:0]  PAGE_PHY = 5'h18,
  parameter logic [4:0]  PAGE_REG = 5'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              mdio_req,
  output logic              mdio_write,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic              mdio_ack,
  input  logic [15:0]       mdio_rdata
);
  eng_state_t  state_q, state_d;
  logic [15:0] lo_q;
  logic        lo_en;
  logic [15:0] page;
  logic [4:0]  data_phy, data_reg;
  logic        lo_first, first_hi;

  swreg_addr_map #(.ADDR_W(ADDR_W), .SWAP_ADDR(LO_FIRST_ADDR)) u_map (
    .addr     (addr),
    .page     (page),
    .data_phy (data_phy),
    .data_reg (data_reg),
    .lo_first (lo_first)
  );

  // Reads always take the low half first; writes only at the swap address
  assign first_hi = write && !lo_first;

  always_comb begin
    state_d    = state_q;
    lo_en      = 1'b0;
    done       = 1'b0;
    mdio_req   = 1'b0;
    mdio_write = 1'b0;
    mdio_phy   = '0;
    mdio_reg   = '0;
    mdio_wdata = '0;
    case (state_q)
      E_IDLE: if (start) state_d = E_PAGE;
      E_PAGE: begin
        mdio_req   = 1'b1;
        mdio_write = 1'b1;
        mdio_phy   = PAGE_PHY;
        mdio_reg   = PAGE_REG;
        mdio_wdata = page;
        if (mdio_ack) state_d = E_FIRST;
      end
      E_FIRST: begin
        mdio_req   = 1'b1;
        mdio_write = write;
        mdio_phy   = data_phy;
        mdio_reg   = {data_reg[4:1], first_hi};
        mdio_wdata = first_hi ? wdata[31:16] : wdata[15:0];
        if (mdio_ack) begin
          lo_en   = !write;
          state_d = E_SECOND;
        end
      end
      E_SECOND: begin
        mdio_req   = 1'b1;
        mdio_write = write;
        mdio_phy   = data_phy;
        mdio_reg   = {data_reg[4:1], !first_hi};
        mdio_wdata = first_hi ? wdata[15:0] : wdata[31:16];
        if (mdio_ack) begin
          done    = 1'b1;
          state_d = E_IDLE;
        end
      end
      default: state_d = E_IDLE;
    endcase
  end

  // Valid in the cycle done is high: high half is on the bus right now
  assign rdata = {mdio_rdata, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= E_IDLE;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (lo_en) lo_q <= mdio_rdata;
    end
  end

  // R10: request and its fields hold until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_write) && $stable(mdio_phy)
                                 && $stable(mdio_reg) && $stable(mdio_wdata)));

  // R1: the first transaction of every access is the page-select write
  p_page_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == E_IDLE && start) |=> (mdio_req && mdio_write
                                      && mdio_phy == PAGE_PHY && mdio_reg == PAGE_REG));

  // R2: data-phase PHY numbers lie in 0x10..0x17
  p_data_phy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && state_q != E_PAGE) |-> (mdio_phy[4:3] == 2'b10));
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
  import swreg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter logic [4:0]  PAGE_PHY = 5'h18,
  parameter logic [4:0]  PAGE_REG = 5'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_phy_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [4:0]        req_dev_phy,
  input  logic [4:0]        req_dev_reg,
  output logic              ready,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              err,
  output logic              mdio_req,
  output logic              mdio_write,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic              mdio_ack,
  input  logic [15:0]       mdio_rdata,
  input  logic              mdio_fail
);
  seq_state_t        state_q, state_d;
  logic              launched_q, launched_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [31:0]       rdata_q, rdata_d;
  logic              rdata_en, cap_en;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;
  logic [4:0]        dphy_q, dreg_q;

  logic              eng_start, eng_write, eng_done;
  logic [ADDR_W-1:0] eng_addr;
  logic [31:0]       eng_wdata, eng_rdata, cmd_word;

  always_comb begin
    cmd_word                        = '0;
    cmd_word[MB_BUSY]               = 1'b1;
    cmd_word[MB_GO]                 = 1'b1;
    cmd_word[MB_RD]                 = !write_q;
    cmd_word[MB_PHY_LSB +: 5]       = dphy_q;
    cmd_word[MB_REG_LSB +: 5]       = dreg_q;
    cmd_word[15:0]                  = write_q ? wdata_q[15:0] : 16'h0;
  end

  assign eng_start = (state_q != T_IDLE) && !launched_q;
  assign eng_addr  = (state_q == T_DIRECT) ? addr_q : ADDR_W'(MBOX_ADDR);
  assign eng_write = (state_q == T_DIRECT) ? write_q : (state_q == T_CMD);
  assign eng_wdata = (state_q == T_DIRECT) ? wdata_q : cmd_word;

  swreg_word_engine #(.ADDR_W(ADDR_W), .PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (eng_start),
    .write      (eng_write),
    .addr       (eng_addr),
    .wdata      (eng_wdata),
    .done       (eng_done),
    .rdata      (eng_rdata),
    .mdio_req   (mdio_req),
    .mdio_write (mdio_write),
    .mdio_phy   (mdio_phy),
    .mdio_reg   (mdio_reg),
    .mdio_wdata (mdio_wdata),
    .mdio_ack   (mdio_ack),
    .mdio_rdata (mdio_rdata)
  );

  always_comb begin
    state_d    = state_q;
    launched_d = launched_q;
    done_d     = 1'b0;
    rdata_en   = 1'b0;
    rdata_d    = rdata_q;
    cap_en     = 1'b0;
    if (eng_start) launched_d = 1'b1;
    if (eng_done)  launched_d = 1'b0;
    case (state_q)
      T_IDLE: if (req_valid) begin
        cap_en  = 1'b1;
        state_d = req_phy_mode ? T_DUMMY : T_DIRECT;
      end
      T_DIRECT: if (eng_done) begin
        state_d = T_IDLE;
        done_d  = 1'b1;
        if (!write_q) begin
          rdata_en = 1'b1;
          rdata_d  = eng_rdata;
        end
      end
      T_DUMMY: if (eng_done) state_d = T_CMD;
      T_CMD:   if (eng_done) state_d = T_POLL;
      T_POLL:  if (eng_done && !eng_rdata[MB_BUSY]) begin
        state_d  = T_IDLE;
        done_d   = 1'b1;
        rdata_en = 1'b1;
        rdata_d  = {16'h0, eng_rdata[15:0]};
      end
      default: state_d = T_IDLE;
    endcase
    err_d = cap_en ? 1'b0 : (err_q | ((state_q != T_IDLE) && mdio_ack && mdio_fail));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= T_IDLE;
      launched_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
      write_q    <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      dphy_q     <= '0;
      dreg_q     <= '0;
    end else begin
      state_q    <= state_d;
      launched_q <= launched_d;
      done_q     <= done_d;
      err_q      <= err_d;
      if (rdata_en) rdata_q <= rdata_d;
      if (cap_en) begin
        write_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        dphy_q  <= req_dev_phy;
        dreg_q  <= req_dev_reg;
      end
    end
  end

  assign ready = (state_q == T_IDLE);
  assign done  = done_q;
  assign rdata = rdata_q;
  assign err   = err_q;

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a busy bridge keeps its captured request
  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(addr_q) && $stable(wdata_q) && $stable(write_q)));

  // R11: an idle bridge drives no management traffic
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mdio_req);

  // R8: the mailbox command carries busy, go and the read flag
  p_cmd_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == T_CMD) |-> (eng_write && eng_wdata[MB_BUSY] && eng_wdata[MB_GO]
                            && (eng_wdata[MB_RD] == !write_q)));
endmodule

// File: tb/swreg_bridge_tb.sv
module swreg_bridge_tb;
  localparam int ADDR_W = 19;
  localparam logic [15:0] MB_LO = 16'h5A3C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0, req_phy_mode = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [4:0]        req_dev_phy = '0, req_dev_reg = '0;
  logic              ready, done, err;
  logic [31:0]       rdata;
  logic              mdio_req, mdio_write;
  logic [4:0]        mdio_phy, mdio_reg;
  logic [15:0]       mdio_wdata;
  logic              mdio_ack = 1'b0, mdio_fail = 1'b0;
  logic [15:0]       mdio_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat = 0, wcnt = 0, fail_idx = -1, log_n = 0, mbox_cnt = 0, ack_cyc = 0;
  logic [15:0] pg = '0;
  logic        l_wr  [0:255];
  logic [4:0]  l_phy [0:255];
  logic [4:0]  l_reg [0:255];
  logic [15:0] l_dat [0:255];

  swreg_bridge #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy_mode(req_phy_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_dev_phy(req_dev_phy), .req_dev_reg(req_dev_reg), .ready(ready), .done(done),
    .rdata(rdata), .err(err), .mdio_req(mdio_req), .mdio_write(mdio_write),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata), .mdio_fail(mdio_fail));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] half_val(logic [15:0] p, logic [4:0] ph, logic [4:0] rg);
    return {p[5:0], ph[2:0], 2'b01, rg};
  endfunction

  // Management-bus responder with a small switch model
  always @(negedge clk) begin
    if (!rst_n) begin
      mdio_ack = 1'b0; mdio_fail = 1'b0; wcnt = 0;
    end else if (mdio_ack) begin
      mdio_ack = 1'b0; mdio_fail = 1'b0;
    end else if (mdio_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0; mdio_ack = 1'b1; mdio_fail = (log_n == fail_idx); ack_cyc = cyc;
        if (log_n < 256) begin
          l_wr[log_n] = mdio_write; l_phy[log_n] = mdio_phy;
          l_reg[log_n] = mdio_reg; l_dat[log_n] = mdio_wdata;
        end
        log_n++;
        if (mdio_write) begin
          if (mdio_phy == 5'h18 && mdio_reg == 5'h00) pg = mdio_wdata;
          else if (pg == 16'h0 && mdio_phy == 5'h12 && mdio_reg == 5'h0D && mdio_wdata[15])
            mbox_cnt = 3;
        end else if (pg == 16'h0 && mdio_phy == 5'h12 && mdio_reg == 5'h0C) mdio_rdata = MB_LO;
        else if (pg == 16'h0 && mdio_phy == 5'h12 && mdio_reg == 5'h0D) begin
          mdio_rdata = {(mbox_cnt > 0), 15'h0};
          if (mbox_cnt > 0) mbox_cnt--;
        end else mdio_rdata = half_val(pg, mdio_phy, mdio_reg);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_tx(input int idx, input logic wr, input logic [4:0] ph, input logic [4:0] rg,
                        input logic [15:0] dat, input string tag);
    logic [31:0] a, e;
    a = {10'h0, l_wr[idx], l_phy[idx], l_reg[idx], wr ? l_dat[idx] : 16'h0};
    e = {10'h0, wr, ph, rg, wr ? dat : 16'h0};
    check(a == e, tag, a, e);
  endtask

  // Issue one request and wait for done; returns the log base index
  task automatic run_req(input logic wr, input logic pm, input logic [ADDR_W-1:0] a,
                         input logic [31:0] wd, input logic [4:0] dp, input logic [4:0] dr,
                         output int base);
    int t;
    @(negedge clk);
    t = 0;
    while (!ready && t < 1000) begin @(negedge clk); t++; end
    base = log_n;
    req_valid = 1'b1; req_write = wr; req_phy_mode = pm; req_addr = a;
    req_wdata = wd; req_dev_phy = dp; req_dev_reg = dr;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(done == 1'b1, "R6 done seen", {31'h0, done}, 32'h1);
    check(cyc == ack_cyc + 1, "R6 done one cycle after last ack", cyc, ack_cyc + 1);
  endtask

  task automatic post_done_check();
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic t_reset();
    check(ready == 1'b1, "R11 ready after reset", {31'h0, ready}, 32'h1);
    check(done == 1'b0, "R11 done after reset", {31'h0, done}, 32'h0);
    check(err == 1'b0, "R11 err after reset", {31'h0, err}, 32'h0);
    check(mdio_req == 1'b0, "R11 mdio_req after reset", {31'h0, mdio_req}, 32'h0);
  endtask

  task automatic t_read(input logic [ADDR_W-1:0] a, input int l);
    int b;
    logic [15:0] p; logic [4:0] ph, rg;
    lat = l;
    p = 16'(a >> 9); ph = 5'h10 | 5'(a[8:6]); rg = {a[5:2], 1'b0};
    run_req(1'b0, 1'b0, a, 32'h0, 5'h0, 5'h0, b);
    check(rdata == {half_val(p, ph, rg | 5'h1), half_val(p, ph, rg)},
          "R3 R10 read data", rdata, {half_val(p, ph, rg | 5'h1), half_val(p, ph, rg)});
    check(log_n - b == 3, "R3 transaction count", log_n - b, 3);
    chk_tx(b, 1'b1, 5'h18, 5'h00, p, "R1 page select write");
    chk_tx(b + 1, 1'b0, ph, rg, 16'h0, "R2 R3 low half read first");
    chk_tx(b + 2, 1'b0, ph, rg | 5'h1, 16'h0, "R2 R3 high half read second");
    post_done_check();
    lat = 0;
  endtask

  task automatic t_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int b;
    logic [15:0] p; logic [4:0] ph, rg; logic [31:0] prev;
    p = 16'(a >> 9); ph = 5'h10 | 5'(a[8:6]); rg = {a[5:2], 1'b0};
    prev = rdata;
    run_req(1'b1, 1'b0, a, d, 5'h0, 5'h0, b);
    chk_tx(b, 1'b1, 5'h18, 5'h00, p, "R1 page select on write");
    if (a == 19'h98) begin
      chk_tx(b + 1, 1'b1, ph, rg, d[15:0], "R4 swap address low half first");
      chk_tx(b + 2, 1'b1, ph, rg | 5'h1, d[31:16], "R4 swap address high half second");
    end else begin
      chk_tx(b + 1, 1'b1, ph, rg | 5'h1, d[31:16], "R4 high half first");
      chk_tx(b + 2, 1'b1, ph, rg, d[15:0], "R4 low half second");
    end
    check(rdata == prev, "R4 write leaves rdata", rdata, prev);
  endtask

  task automatic t_busy_ignore();
    int b, n, t;
    @(negedge clk);
    b = log_n;
    req_valid = 1'b1; req_write = 1'b0; req_phy_mode = 1'b0; req_addr = 19'h00100;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R5 ready low while busy", {31'h0, ready}, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h7FE00; req_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    n = log_n - b;
    check(n == 3, "R5 busy request ignored (transaction count)", n, 3);
    chk_tx(b, 1'b1, 5'h18, 5'h00, 16'h0, "R5 page of first request kept");
    chk_tx(b + 1, 1'b0, 5'h14, 5'h00, 16'h0, "R5 first request read kept");
    check(mdio_req == 1'b0, "R5 no traffic after ignored request", {31'h0, mdio_req}, 32'h0);
  endtask

  task automatic t_fail();
    int b;
    fail_idx = log_n + 1;
    run_req(1'b0, 1'b0, 19'h0010C, 32'h0, 5'h0, 5'h0, b);
    fail_idx = -1;
    check(err == 1'b1, "R7 error latched", {31'h0, err}, 32'h1);
    check(log_n - b == 3, "R7 sequence completes after failure", log_n - b, 3);
    repeat (3) @(negedge clk);
    check(err == 1'b1, "R7 error held while idle", {31'h0, err}, 32'h1);
    run_req(1'b0, 1'b0, 19'h00040, 32'h0, 5'h0, 5'h0, b);
    check(err == 1'b0, "R7 error cleared by next request", {31'h0, err}, 32'h0);
  endtask

  task automatic t_phy(input logic wr, input logic [4:0] dp, input logic [4:0] dr, input logic [15:0] d);
    int b;
    logic [31:0] cmd;
    cmd = 32'hC000_0000 | (wr ? 32'h0 : 32'h0800_0000) | (32'(dp) << 21) | (32'(dr) << 16)
          | (wr ? {16'h0, d} : 32'h0);
    run_req(wr, 1'b1, 19'h0, {16'hFFFF, d}, dp, dr, b);
    check(log_n - b == 18, "R8 R9 mailbox transaction count", log_n - b, 18);
    chk_tx(b + 1, 1'b0, 5'h12, 5'h0C, 16'h0, "R8 dummy mailbox read");
    chk_tx(b + 3, 1'b1, 5'h18, 5'h00, 16'h0, "R8 command page select");
    chk_tx(b + 4, 1'b1, 5'h12, 5'h0C, cmd[15:0], "R8 command low half");
    chk_tx(b + 5, 1'b1, 5'h12, 5'h0D, cmd[31:16], "R8 command high half");
    chk_tx(b + 17, 1'b0, 5'h12, 5'h0D, 16'h0, "R9 final poll high half");
    check(rdata == {16'h0, MB_LO}, "R9 mailbox result", rdata, {16'h0, MB_LO});
    post_done_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read(19'h0010C, 0);
    t_read(19'h7FFFC, 2);
    t_write(19'h00040, 32'h1234ABCD);
    t_write(19'h00098, 32'hCAFE0001);
    t_busy_ignore();
    t_fail();
    t_phy(1'b0, 5'd3, 5'd2, 16'h0);
    t_phy(1'b1, 5'd4, 5'd0, 16'h9000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule